// File: doc/BRIEF.md
# Burst Modulator and Square-Wave Timer

This peripheral owns one 8-bit down counter and an 8-bit reload register that software writes. It drives a single output pin and has two modes. In burst mode the block passes a chosen clock to the pin for a programmed number of pulses and then stops by itself. That clock is either the oscillator clock or the internal cycle tick. In square-wave mode the counter runs from the cycle tick, reloads on every underflow and toggles the pin each time, which gives a free-running signal with a 50% duty cycle.

Software uses two write addresses. Address 0 holds the reload value. Address 1 holds three control bits: run, source and mode select. Writing the control address with the run bit set copies the reload value into the counter and starts it. When a burst ends, the hardware clears the run bit. Software can read the control bits back and poll the run bit to see when a burst has finished. The cycle tick is made inside the block by dividing the oscillator by ten, and it is also driven out on its own port.

Top module: `burst_pwm_timer`

## Requirements
- R1: `cyc_tick` is high for exactly one oscillator cycle in every ten, so its rising edges are 10 clock cycles apart.
- R2: After reset, `pin_out` is low, `ctrl_rdata` reads 3'b000 and no pulse appears on the pin.
- R3: A write with `wr_addr`=1 sets the control bits from `wr_data`: bit 0 is run, bit 1 is source, bit 2 is mode select. If bit 0 is 1, the counter is loaded from the reload register and starts counting.
- R4: Burst mode is selected by bit 2 = 1. A reload value of n-1 produces exactly n pulses on `pin_out`, for any n from 1 to 256. With source = 1, each pulse is one high half of the oscillator clock. With source = 0, each pulse is one clock cycle high, coinciding with `cyc_tick`.
- R5: When a burst ends, the hardware clears the run bit, so `ctrl_rdata[0]` reads 0. `pin_out` then stays low until the next start.
- R6: Writing the control address with run = 0 stops the counter at once. `pin_out` goes low and no further pulses follow.
- R7: Setting run again reuses the stored reload value. A write to the reload register while the counter is running changes only the next start.
- R8: Square-wave mode is bits 2:0 = 3'b001. The pin starts low and toggles after every R+1 cycle ticks, which is 10*(R+1) clock cycles, where R is the reload value. The run bit stays set and the wave continues until software clears run; the pin is then low.
- R9: The control code with bit 2 = 0 and bit 1 = 1 selects no mode. `pin_out` stays low and the counter does not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one clock cycle per write |
| wr_addr | input | 1 | 0 selects the reload register, 1 selects the control bits |
| wr_data | input | 8 | Write data |
| ctrl_rdata | output | 3 | Control bits {mode select, source, run}, with run as maintained by the hardware |
| cyc_tick | output | 1 | Cycle tick: high for one oscillator cycle in every ten |
| pin_out | output | 1 | Modulator / square-wave output |

## Verification
Several properties are checked on every cycle: the tick never stays high for two cycles in a row; a start loads the reload value and sets run; each count step lowers the counter by exactly one; an underflow in burst mode clears run; the square wave changes level only on an underflow; and the pin stays quiet while the block is stopped. Other behaviour can only be seen in the bench scenarios, because it depends on whole sequences. These are the exact pulse count for each reload value and clock source (including 1 and 256 pulses), the square-wave half period, a restart that uses a reload value written mid-run, and the silence of the unused mode code.

// File: rtl/bpw_pkg.sv
`timescale 1ns/1ps
package bpw_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_SQUARE = 2'd2
  } mode_e;

  localparam int unsigned CTL_RUN_BIT = 0;
  localparam int unsigned CTL_SRC_BIT = 1;
  localparam int unsigned CTL_SEL_BIT = 2;

  function automatic mode_e decode_mode(input logic src, input logic sel);
    if (sel)
      return MODE_BURST;
    else if (!src)
      return MODE_SQUARE;
    else
      return MODE_OFF;
  endfunction
endpackage

// File: rtl/bpw_tick_gen.sv
`timescale 1ns/1ps
module bpw_tick_gen #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    tick_d = (cnt_q == LAST);
    if (cnt_q == LAST)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
endmodule

// File: rtl/bpw_ctrl.sv
`timescale 1ns/1ps
module bpw_ctrl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          hw_clr,
  output logic          run_q,
  output logic          src_q,
  output logic          sel_q,
  output logic          load,
  output logic [DW-1:0] reload_q
);
  import bpw_pkg::*;

  logic          ctl_wr, rel_wr;
  logic          run_d, src_d, sel_d;
  logic [DW-1:0] reload_d;

  always_comb begin
    ctl_wr   = wr_en && wr_addr;
    rel_wr   = wr_en && !wr_addr;
    load     = ctl_wr && wr_data[CTL_RUN_BIT];
    reload_d = rel_wr ? wr_data : reload_q;
    run_d    = run_q;
    src_d    = src_q;
    sel_d    = sel_q;
    if (ctl_wr) begin
      run_d = wr_data[CTL_RUN_BIT];
      src_d = wr_data[CTL_SRC_BIT];
      sel_d = wr_data[CTL_SEL_BIT];
    end else if (hw_clr) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      src_q    <= 1'b0;
      sel_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      run_q    <= run_d;
      src_q    <= src_d;
      sel_q    <= sel_d;
      reload_q <= reload_d;
    end
  end

  AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> run_q); // R3
  AST_HW_CLEAR_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !(wr_en && wr_addr)) |=> !run_q); // R5
endmodule

// File: rtl/bpw_counter.sv
`timescale 1ns/1ps
module bpw_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] reload,
  input  logic          active,
  input  logic          step,
  input  logic          autoreload,
  output logic [CW-1:0] cnt_q,
  output logic          underflow
);
  logic [CW-1:0] cnt_d;
  logic          at_zero;

  always_comb begin
    at_zero   = (cnt_q == '0);
    underflow = active && step && at_zero;
    cnt_d     = cnt_q;
    if (load)
      cnt_d = reload;
    else if (active && step) begin
      if (!at_zero)
        cnt_d = cnt_q - 1'b1;
      else if (autoreload)
        cnt_d = reload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload))); // R3
  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/bpw_out.sv
`timescale 1ns/1ps
module bpw_out (
  input  logic           clk,
  input  logic           rst_n,
  input  bpw_pkg::mode_e mode,
  input  logic           src,
  input  logic           active,
  input  logic           tick,
  input  logic           underflow,
  input  logic           load,
  output logic           pin
);
  import bpw_pkg::*;

  logic gate_q, gate_d;
  logic sq_q, sq_d;

  always_comb begin
    gate_d = active && (mode == MODE_BURST) && src;
    sq_d   = sq_q;
    if (load || !(active && (mode == MODE_SQUARE)))
      sq_d = 1'b0;
    else if (underflow)
      sq_d = !sq_q;
  end

  // Enable for the oscillator gate changes only while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else
      gate_q <= gate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sq_q <= 1'b0;
    else
      sq_q <= sq_d;
  end

  always_comb begin
    unique case (mode)
      MODE_BURST:  pin = src ? (clk && gate_q) : (active && tick);
      MODE_SQUARE: pin = sq_q;
      default:     pin = 1'b0;
    endcase
  end

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$past(active)) |-> !pin); // R6
  AST_SQ_TOGGLE_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((sq_q != $past(sq_q)) && $past(active) && !$past(load) && ($past(mode) == MODE_SQUARE))
      |-> $past(underflow)); // R8
endmodule

// File: rtl/burst_pwm_timer.sv
`timescale 1ns/1ps
module burst_pwm_timer #(
  parameter int unsigned DW  = 8,
  parameter int unsigned DIV = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [2:0]    ctrl_rdata,
  output logic          cyc_tick,
  output logic          pin_out
);
  import bpw_pkg::*;

  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic          run_q, src_q, sel_q, load;
  logic [DW-1:0] reload_q, cnt_q;
  logic          underflow, hw_clr, active, step, autoreload;
  mode_e         mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= '0;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  bpw_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (cyc_tick)
  );

  bpw_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .hw_clr   (hw_clr),
    .run_q    (run_q),
    .src_q    (src_q),
    .sel_q    (sel_q),
    .load     (load),
    .reload_q (reload_q)
  );

  always_comb begin
    mode       = decode_mode(src_q, sel_q);
    active     = run_q && (mode != MODE_OFF);
    step       = ((mode == MODE_BURST) && src_q) ? 1'b1 : cyc_tick;
    autoreload = (mode == MODE_SQUARE);
    hw_clr     = underflow && (mode == MODE_BURST);
    ctrl_rdata = {sel_q, src_q, run_q};
  end

  bpw_counter #(.CW(DW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (load),
    .reload     (reload_q),
    .active     (active),
    .step       (step),
    .autoreload (autoreload),
    .cnt_q      (cnt_q),
    .underflow  (underflow)
  );

  bpw_out u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode),
    .src       (src_q),
    .active    (active),
    .tick      (cyc_tick),
    .underflow (underflow),
    .load      (load),
    .pin       (pin_out)
  );
endmodule

// File: tb/burst_pwm_timer_bench.sv
`timescale 1ns/1ps
module burst_pwm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] ctrl_rdata;
  logic       cyc_tick;
  logic       pin_out;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge pin_out) pulses = pulses + 1;

  burst_pwm_timer u_burst_pwm_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl_rdata (ctrl_rdata),
    .cyc_tick   (cyc_tick),
    .pin_out    (pin_out)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ctrl_rdata[0] == 1'b0) break;
    end
  endtask

  task automatic t_reset;
    repeat (30) @(negedge clk);
    chk("R2 pin after reset", pin_out, 0);
    chk("R2 ctrl after reset", ctrl_rdata, 0);
    chk("R2 no pulses after reset", pulses, 0);
  endtask

  task automatic t_tick;
    time ta, tb;
    int hi;
    @(posedge cyc_tick); ta = $time;
    @(posedge cyc_tick); tb = $time;
    chk("R1 tick period cycles", (tb - ta) / 10, 10);
    hi = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cyc_tick) hi++;
    end
    chk("R1 tick high cycles per 100", hi, 10);
  endtask

  task automatic t_burst(input logic src, input int n);
    wr(1'b0, 8'(n - 1));
    pulses = 0;
    wr(1'b1, {5'b0, 1'b1, src, 1'b1});
    wait_done(n * 12 + 60);
    chk($sformatf("R4 pulses src=%0d n=%0d", src, n), pulses, n);
    chk("R5 run cleared after burst", ctrl_rdata[0], 0);
    repeat (30) @(negedge clk);
    chk("R5 no pulses after burst", pulses, n);
    chk("R5 pin low after burst", pin_out, 0);
  endtask

  task automatic t_stop_restart;
    int p;
    wr(1'b0, 8'd99);
    pulses = 0;
    wr(1'b1, 8'b111);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'b110);
    p = pulses;
    chk("R6 stopped early", (p > 0 && p < 100) ? 1 : 0, 1);
    repeat (30) @(negedge clk);
    chk("R6 no pulses after stop", pulses, p);
    chk("R6 pin low after stop", pin_out, 0);
    chk("R6 run reads 0", ctrl_rdata[0], 0);
    pulses = 0;
    wr(1'b1, 8'b111);
    wait_done(400);
    chk("R7 restart reuses reload", pulses, 100);
    wr(1'b0, 8'd19);
    pulses = 0;
    wr(1'b1, 8'b111);
    repeat (3) @(negedge clk);
    wr(1'b0, 8'd4);
    wait_done(400);
    chk("R7 mid-run reload write ignored", pulses, 20);
    pulses = 0;
    wr(1'b1, 8'b111);
    wait_done(400);
    chk("R7 next start uses new reload", pulses, 5);
  endtask

  task automatic t_square(input int r);
    time ta, tb, tc;
    int p;
    wr(1'b0, 8'(r));
    wr(1'b1, 8'b001);
    chk("R8 pin starts low", pin_out, 0);
    @(posedge pin_out); ta = $time;
    @(negedge pin_out); tb = $time;
    @(posedge pin_out); tc = $time;
    chk($sformatf("R8 high time r=%0d", r), (tb - ta) / 10, 10 * (r + 1));
    chk($sformatf("R8 low time r=%0d", r), (tc - tb) / 10, 10 * (r + 1));
    chk("R8 run stays set", ctrl_rdata[0], 1);
    wr(1'b1, 8'b000);
    repeat (3) @(negedge clk);
    chk("R8 pin low after clear", pin_out, 0);
    p = pulses;
    repeat (60) @(negedge clk);
    chk("R8 no edges after clear", pulses, p);
  endtask

  task automatic t_off_code;
    wr(1'b0, 8'd0);
    pulses = 0;
    wr(1'b1, 8'b011);
    repeat (60) @(negedge clk);
    chk("R9 no pulses in unused code", pulses, 0);
    chk("R9 pin low in unused code", pin_out, 0);
    wr(1'b1, 8'b000);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tick();
    t_burst(1'b1, 5);
    t_burst(1'b1, 1);
    t_burst(1'b1, 256);
    t_burst(1'b0, 3);
    t_burst(1'b0, 1);
    t_stop_restart();
    t_square(2);
    t_square(0);
    t_off_code();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule